// File: doc/BRIEF.md
# Divided One-Shot Countdown Timer

This block is the countdown timer of a per-processor interrupt controller. Software loads a 32-bit start value. The counter then steps down by one at the end of every count unit. A count unit lasts sixteen input clocks times a power-of-two divisor, and the divisor is chosen through a small divide-configuration register. The remaining count can be read back at any moment. When the count runs out, the block emits a one-cycle expiry pulse. Whatever logic sits next to the block decides how to deliver that pulse as an interrupt.

All three registers share a single write port that carries a 2-bit select. A write that selects the current-count register is dropped. A write of zero to the start value halts the timer and produces no pulse. A new divisor does not cut the running count unit short: it applies from the next unit boundary. Each new start value restarts the prescaler from zero.

Top module: `divcount_timer`

## Requirements
- R1: After reset, `init_count`, `cur_count` and `div_cfg` all read zero and `expire` is low.
- R2: A write with `wr_sel`=2 stores only `wr_data` bits 3, 1 and 0. `div_cfg` returns them in the same bit positions and reads zero in every other bit.
- R3: The divide code is {bit3, bit1, bit0}. The shift is (code + 1) mod 8 and the count unit is 16 << shift clocks. Code 111 therefore gives 16 clocks, code 000 gives 32 clocks and code 110 gives 2048 clocks.
- R4: A write with `wr_sel`=0 loads `wr_data` into both `init_count` and `cur_count`, and both show the value one cycle after the write edge.
- R5: While the count is nonzero, `cur_count` drops by exactly one at the end of each count unit and otherwise stays unchanged. The first decrement comes one full unit after the load edge.
- R6: When the count steps from 1 to 0, `expire` is high for exactly one cycle, in the same cycle that `cur_count` first reads 0. The count then holds at zero.
- R7: Loading a start value of zero leaves the timer idle at zero, and `expire` never rises.
- R8: Writes with `wr_sel`=1 (current count) or `wr_sel`=3 (unused) change no register.
- R9: A divide write made partway through a count unit leaves that unit at its old length. The new length applies from the following unit.
- R10: Loading a new start value while the timer runs restarts the countdown from the new value, and the next decrement comes a full unit after the reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 start value, 1 current count, 2 divide, 3 unused |
| wr_data | input | CNT_W | Write data |
| init_count | output | CNT_W | Last start value written |
| cur_count | output | CNT_W | Remaining whole count units |
| div_cfg | output | CNT_W | Divide configuration readback (bits 3, 1, 0) |
| expire | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The bound checker watches, on every cycle, the local relations between the signals. The count may only hold or drop by one, and it may drop only on a unit tick. A load must show its data on the next cycle. The expiry pulse must be a single cycle long and can appear only while the count is zero. Zero must be sticky unless a load occurs, and the unused divide bits must read zero. The bench scenarios cover what needs a long view: the exact unit lengths for the three divide codes, the mid-unit divisor change, the fresh prescale after a reload, and the absence of any pulse after a zero load.

// File: rtl/divcount_pkg.sv
package divcount_pkg;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_CUR   = 2'd1,
    SEL_DIV   = 2'd2,
    SEL_NONE  = 2'd3
  } tmr_sel_e;

  localparam int SHIFT_W   = 3;
  localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;

  // Rotated decode: code 7 wraps to shift 0, code 0 gives shift 1.
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [2:0] code);
    return code + 3'd1;
  endfunction

endpackage

// File: rtl/divcount_cfg_regs.sv
module divcount_cfg_regs
  import divcount_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  tmr_sel_e         wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       div_bits,
  output logic             load_evt,
  output logic [CNT_W-1:0] start_q,
  output logic [2:0]       code_q
);

  logic div_wr;

  assign load_evt = wr_en && (wr_sel == SEL_START);
  assign div_wr   = wr_en && (wr_sel == SEL_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      code_q  <= '0;
    end else begin
      if (load_evt) start_q <= wr_data;
      if (div_wr)   code_q  <= div_bits;
    end
  end

endmodule

// File: rtl/divcount_prescaler.sv
module divcount_prescaler
  import divcount_pkg::*;
#(
  parameter int PRE_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_evt,
  input  logic       run,
  input  logic [2:0] code_q,
  output logic       unit_tick
);

  localparam int PRE_W = PRE_LOG2 + MAX_SHIFT;

  logic [PRE_W-1:0]   pre_cnt;
  logic [SHIFT_W-1:0] act_shift;
  logic               at_last;

  // Last prescaler value of a unit: (16 << shift) - 1.
  function automatic logic [PRE_W-1:0] last_of(input logic [SHIFT_W-1:0] sh);
    return {PRE_W{1'b1}} >> (SHIFT_W'(MAX_SHIFT) - sh);
  endfunction

  assign at_last   = (pre_cnt == last_of(act_shift));
  assign unit_tick = run && !load_evt && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      act_shift <= '0;
    end else if (load_evt) begin
      pre_cnt   <= '0;
      act_shift <= code_to_shift(code_q);
    end else if (run) begin
      if (at_last) begin
        pre_cnt   <= '0;
        act_shift <= code_to_shift(code_q);
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end else begin
      pre_cnt <= '0;
    end
  end

endmodule

// File: rtl/divcount_down_counter.sv
module divcount_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt,
  input  logic [CNT_W-1:0] load_val,
  input  logic             unit_tick,
  output logic [CNT_W-1:0] count_q,
  output logic             expire_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      expire_q <= 1'b0;
    end else if (load_evt) begin
      count_q  <= load_val;
      expire_q <= 1'b0;
    end else if (unit_tick) begin
      count_q  <= count_q - 1'b1;
      expire_q <= (count_q == CNT_W'(1));
    end else begin
      expire_q <= 1'b0;
    end
  end

endmodule

// File: rtl/divcount_timer.sv
module divcount_timer
  import divcount_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PRE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] init_count,
  output logic [CNT_W-1:0] cur_count,
  output logic [CNT_W-1:0] div_cfg,
  output logic             expire
);

  logic       load_evt;
  logic       unit_tick;
  logic       run;
  logic [2:0] code_q;

  divcount_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (tmr_sel_e'(wr_sel)),
    .wr_data  (wr_data),
    .div_bits ({wr_data[3], wr_data[1], wr_data[0]}),
    .load_evt (load_evt),
    .start_q  (init_count),
    .code_q   (code_q)
  );

  assign run = (cur_count != '0);

  divcount_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_evt  (load_evt),
    .run       (run),
    .code_q    (code_q),
    .unit_tick (unit_tick)
  );

  divcount_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_evt  (load_evt),
    .load_val  (wr_data),
    .unit_tick (unit_tick),
    .count_q   (cur_count),
    .expire_q  (expire)
  );

  assign div_cfg = CNT_W'({code_q[2], 1'b0, code_q[1:0]});

endmodule

// File: rtl/divcount_timer_chk.sv
module divcount_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_evt,
  input logic             unit_tick,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] init_count,
  input logic [CNT_W-1:0] cur_count,
  input logic [CNT_W-1:0] div_cfg,
  input logic             expire
);

  p_div_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_cfg[CNT_W-1:4] == '0) && !div_cfg[2]);

  p_load_cur_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cur_count == $past(wr_data)));

  p_load_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (init_count == $past(wr_data)));

  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    unit_tick |=> (cur_count == $past(cur_count) - 1'b1));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !unit_tick) |=> $stable(cur_count));

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

  p_pulse_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (cur_count == '0));

  p_zero_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_count == '0) && !load_evt) |=> (cur_count == '0));

  p_zero_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && (wr_data == '0)) |=> !expire);

endmodule

bind divcount_timer divcount_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_evt   (load_evt),
  .unit_tick  (unit_tick),
  .wr_data    (wr_data),
  .init_count (init_count),
  .cur_count  (cur_count),
  .div_cfg    (div_cfg),
  .expire     (expire)
);

// File: tb/divcount_timer_tb.sv
module divcount_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] init_count, cur_count, div_cfg;
  logic        expire;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  divcount_timer u_dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
    .wr_data (wr_data), .init_count (init_count), .cur_count (cur_count),
    .div_cfg (div_cfg), .expire (expire)
  );

  always @(negedge clk) if (rst_n && expire) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge; returns at the negedge after it.
  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_r1();
    check("R1 init", init_count, 0);
    check("R1 cur", cur_count, 0);
    check("R1 div", div_cfg, 0);
    check("R1 expire", {31'd0, expire}, 0);
  endtask

  task automatic t_mask_r2();
    wr(2'd2, 32'hFFFF_FFFF);
    check("R2 all ones", div_cfg, 32'h0000_000B);
    wr(2'd2, 32'hFFFF_FFF4);
    check("R2 unused bits", div_cfg, 32'h0);
  endtask

  task automatic t_div1_r5_r6();
    int p0;
    wr(2'd2, 32'hB);                 // code 111 -> 16 clocks
    wr(2'd0, 32'd3);
    p0 = pulses;
    check("R4 load cur", cur_count, 3);
    check("R4 load init", init_count, 3);
    idle(15); check("R5 hold before unit", cur_count, 3);
    idle(1);  check("R5 first step", cur_count, 2);
    idle(31); check("R6 before zero", {31'd0, expire}, 0);
    check("R5 at one", cur_count, 1);
    idle(1);  check("R6 pulse", {31'd0, expire}, 1);
    check("R6 zero", cur_count, 0);
    idle(1);  check("R6 single", {31'd0, expire}, 0);
    idle(40); check("R6 sticky", cur_count, 0);
    check("R6 one pulse", pulses - p0, 1);
  endtask

  task automatic t_div2_r3();
    wr(2'd2, 32'h0);                 // code 000 -> 32 clocks
    wr(2'd0, 32'd2);
    idle(31); check("R3 code000 hold", cur_count, 2);
    idle(1);  check("R3 code000 step", cur_count, 1);
    idle(32); check("R3 code000 zero", cur_count, 0);
  endtask

  task automatic t_div128_r3();
    wr(2'd2, 32'hA);                 // code 110 -> 2048 clocks
    wr(2'd0, 32'd1);
    idle(2047); check("R3 code110 hold", cur_count, 1);
    idle(1);    check("R3 code110 step", cur_count, 0);
    check("R3 code110 pulse", {31'd0, expire}, 1);
  endtask

  task automatic t_zero_r7();
    int p0;
    wr(2'd2, 32'hB);
    wr(2'd0, 32'd3);
    idle(4);
    p0 = pulses;
    wr(2'd0, 32'd0);
    check("R7 stopped", cur_count, 0);
    idle(100);
    check("R7 still zero", cur_count, 0);
    check("R7 no pulse", pulses - p0, 0);
  endtask

  task automatic t_ignored_r8();
    wr(2'd2, 32'hB);
    wr(2'd0, 32'd7);
    idle(2);
    wr(2'd1, 32'h55);
    check("R8 cur write", cur_count, 7);
    wr(2'd3, 32'h66);
    check("R8 sel3 cur", cur_count, 7);
    check("R8 sel3 init", init_count, 7);
    check("R8 sel3 div", div_cfg, 32'hB);
  endtask

  task automatic t_midunit_r9();
    wr(2'd2, 32'hB);
    wr(2'd0, 32'd5);
    idle(5);
    wr(2'd2, 32'h0);                 // lands 6 clocks into a 16-clock unit
    idle(9);  check("R9 old unit hold", cur_count, 5);
    idle(1);  check("R9 old unit end", cur_count, 4);
    idle(31); check("R9 new unit hold", cur_count, 4);
    idle(1);  check("R9 new unit end", cur_count, 3);
  endtask

  task automatic t_reload_r10();
    wr(2'd2, 32'hB);
    wr(2'd0, 32'd10);
    idle(8);
    wr(2'd0, 32'd4);
    check("R10 reload", cur_count, 4);
    idle(15); check("R10 fresh prescale", cur_count, 4);
    idle(1);  check("R10 step", cur_count, 3);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset_r1();
    t_mask_r2();
    t_div1_r5_r6();
    t_div2_r3();
    t_div128_r3();
    t_zero_r7();
    t_ignored_r8();
    t_midunit_r9();
    t_reload_r10();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule